// File: doc/BRIEF.md
# Multi-Hart Machine Timer with Compare

This block keeps one free-running 64-bit time counter shared by a group of harts, plus one 64-bit compare value per hart. Each hart gets a timer-interrupt line that is high whenever its compare value has been reached or passed by the time counter. The counter advances by one on each clock in which a timebase tick-enable input is high. The timebase is assumed to be already in the block's clock domain.

Software reaches the counter and the compare values through a simple single-cycle register bus. Each access is either a 32-bit word or a 64-bit doubleword, in little-endian order. A 32-bit access picks the low or high half of a 64-bit value by its byte offset. The hart count and the base offsets of the compare region and of the time counter are parameters. Time can be rewritten at any moment, and every hart's interrupt follows the new value.

Top module: `hart_timer_cmp`

## Requirements
- R1: On reset, time reads zero, every compare value reads all ones and every interrupt line is low.
- R2: Time increases by exactly one after each clock edge at which `tick_en` is high and no accepted time write occurs.
- R3: An accepted write to time in a cycle with `tick_en` high loads the written value and skips that cycle's increment.
- R4: Hart i's compare value occupies bytes CMP_BASE + 8*i to CMP_BASE + 8*i + 7. Byte offset 0 of this slot is the low half and byte offset 4 is the high half. Offsets from CMP_BASE + 8*NUM_HARTS upward do not reach any compare value.
- R5: A word write (`req_dword`=0) to one half of time or of a compare value replaces only that half and keeps the other half.
- R6: A doubleword write (`req_dword`=1) aimed at byte 4 of a compare slot, or at TIME_BASE+4, changes no state. In particular, time still counts ticks during it.
- R7: `timer_irq[i]` is high one clock after compare[i] <= time holds, and it is low one clock after compare[i] > time holds.
- R8: After a write to time, every hart's interrupt line is recomputed against the new time. A line that was high can therefore drop.
- R9: A read at an unmapped or non-4-byte-aligned offset returns zero, and a write there changes no state.
- R10: Read data appears on `rsp_rdata` one clock after the read request. A word read returns the selected half in bits 31:0 with bits 63:32 zero. A read at byte 4 returns the high half in this way whatever its size. A doubleword read at byte 0 returns the full value. `rsp_rdata` is zero after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase tick: time advances by one when high |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dword | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 64 | Write data; word writes use bits 31:0 |
| rsp_rdata | output | 64 | Read data, registered |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
The bench covers two cases where work lands in the same cycle. In the first, a time write arrives in a cycle where `tick_en` is high. A full write must win, and a write aimed at the high half with the wrong size must let the tick through. In the second, a compare write lands while time is climbing past the old or the new compare value. A reference model built from the requirements advances in lockstep with the design, and both the interrupt vector and the read data are compared on every clock. This makes any one-cycle slip in priority or in interrupt timing visible right away.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;

    localparam int TIME_W = 64;
    localparam int HALF_W = TIME_W / 2;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_TIME = 2'd1,
        TGT_CMP  = 2'd2
    } target_e;

    typedef struct packed {
        logic              ok;
        logic [TIME_W-1:0] val;
    } merge_t;

    // Folds a bus write into a 64-bit value; ok=0 marks a rejected access
    function automatic merge_t merge_write(input logic [TIME_W-1:0] old_v,
                                           input logic [TIME_W-1:0] wd,
                                           input logic              dword,
                                           input logic              hi);
        merge_t r;
        r.ok  = 1'b1;
        r.val = old_v;
        if (dword && hi) begin
            r.ok = 1'b0;
        end else if (dword) begin
            r.val = wd;
        end else if (hi) begin
            r.val = {wd[HALF_W-1:0], old_v[HALF_W-1:0]};
        end else begin
            r.val = {old_v[TIME_W-1:HALF_W], wd[HALF_W-1:0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/htc_decode.sv
module htc_decode
    import hart_timer_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          NUM_HARTS = 4,
    parameter int unsigned CMP_BASE  = 32'h0000,
    parameter int unsigned TIME_BASE = 32'h7FF8,
    localparam int         IDX_W     = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output target_e           tgt,
    output logic              hi,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [31:0] CMP_SPAN = 32'(NUM_HARTS * 8);

    logic [31:0] cmp_off;
    logic [31:0] addr_w;

    always_comb begin
        addr_w  = 32'(addr);
        cmp_off = addr_w - CMP_BASE;
        tgt     = TGT_NONE;
        hi      = addr_w[2];
        idx     = cmp_off[3 +: IDX_W];
        if (addr_w[1:0] == 2'b00) begin
            if (cmp_off < CMP_SPAN) begin
                tgt = TGT_CMP;
            end else if ((addr_w & ~32'h7) == TIME_BASE) begin
                tgt = TGT_TIME;
            end
        end
    end

endmodule

// File: rtl/htc_time.sv
module htc_time
    import hart_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              wr_dword,
    input  logic              wr_hi,
    input  logic [TIME_W-1:0] wr_data,
    output logic [TIME_W-1:0] time_o
);

    typedef struct packed {
        logic [TIME_W-1:0] cnt;
    } time_state_t;

    time_state_t st_d, st_q;
    merge_t      wr_res;

    always_comb begin
        st_d   = st_q;
        wr_res = merge_write(st_q.cnt, wr_data, wr_dword, wr_hi);
        if (wr_en && wr_res.ok) begin
            st_d.cnt = wr_res.val;
        end else if (tick_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign time_o = st_q.cnt;

    assert_tick_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_en) |=> (time_o == $past(time_o) + 1'b1));

    assert_write_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dword && !wr_hi) |=> (time_o == $past(wr_data)));

    assert_bad_hi_write_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dword && wr_hi && !tick_en) |=> $stable(time_o));

    assert_low_half_keeps_high_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_dword && !wr_hi) |=> (time_o[TIME_W-1:HALF_W] == $past(time_o[TIME_W-1:HALF_W])));

endmodule

// File: rtl/htc_cmp_slot.sv
module htc_cmp_slot
    import hart_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_dword,
    input  logic              wr_hi,
    input  logic [TIME_W-1:0] wr_data,
    input  logic [TIME_W-1:0] time_i,
    output logic [TIME_W-1:0] cmp_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [TIME_W-1:0] cmp;
        logic              irq;
    } slot_state_t;

    slot_state_t st_d, st_q;
    merge_t      wr_res;

    always_comb begin
        st_d   = st_q;
        wr_res = merge_write(st_q.cmp, wr_data, wr_dword, wr_hi);
        if (wr_en && wr_res.ok) begin
            st_d.cmp = wr_res.val;
        end
        st_d.irq = (st_q.cmp <= time_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cmp <= '1;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o = st_q.cmp;
    assign irq_o = st_q.irq;

    assert_irq_rise_reached_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(cmp_o <= time_i));

    assert_irq_fall_ahead_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> $past(cmp_o > time_i));

    assert_bad_hi_write_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_dword && wr_hi) |=> $stable(cmp_o));

    assert_high_half_keeps_low_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_dword && wr_hi) |=> (cmp_o[HALF_W-1:0] == $past(cmp_o[HALF_W-1:0])));

endmodule

// File: rtl/hart_timer_cmp.sv
module hart_timer_cmp
    import hart_timer_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          NUM_HARTS = 4,
    parameter int unsigned CMP_BASE  = 32'h0000,
    parameter int unsigned TIME_BASE = 32'h7FF8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_dword,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [63:0]          req_wdata,
    output logic [63:0]          rsp_rdata,
    output logic [NUM_HARTS-1:0] timer_irq
);

    localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    typedef struct packed {
        logic [TIME_W-1:0] rdata;
    } rd_state_t;

    target_e           dec_tgt;
    logic              dec_hi;
    logic [IDX_W-1:0]  dec_idx;
    logic [TIME_W-1:0] time_val;
    logic [TIME_W-1:0] cmp_val [NUM_HARTS];
    logic              time_wr;
    logic [TIME_W-1:0] sel_val;
    rd_state_t         rd_d, rd_q;

    htc_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_HARTS(NUM_HARTS),
        .CMP_BASE (CMP_BASE),
        .TIME_BASE(TIME_BASE)
    ) u_decode (
        .addr(req_addr),
        .tgt (dec_tgt),
        .hi  (dec_hi),
        .idx (dec_idx)
    );

    assign time_wr = req_valid && req_write && (dec_tgt == TGT_TIME);

    htc_time u_time (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wr_en   (time_wr),
        .wr_dword(req_dword),
        .wr_hi   (dec_hi),
        .wr_data (req_wdata),
        .time_o  (time_val)
    );

    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_slot
        logic slot_wr;
        assign slot_wr = req_valid && req_write && (dec_tgt == TGT_CMP)
                         && (dec_idx == IDX_W'(g));
        htc_cmp_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (slot_wr),
            .wr_dword(req_dword),
            .wr_hi   (dec_hi),
            .wr_data (req_wdata),
            .time_i  (time_val),
            .cmp_o   (cmp_val[g]),
            .irq_o   (timer_irq[g])
        );
    end

    always_comb begin
        rd_d    = '0;
        sel_val = (dec_tgt == TGT_TIME) ? time_val : cmp_val[dec_idx];
        if (req_valid && !req_write && (dec_tgt != TGT_NONE)) begin
            if (dec_hi) begin
                rd_d.rdata = {{HALF_W{1'b0}}, sel_val[TIME_W-1:HALF_W]};
            end else if (req_dword) begin
                rd_d.rdata = sel_val;
            end else begin
                rd_d.rdata = {{HALF_W{1'b0}}, sel_val[HALF_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rsp_rdata = rd_q.rdata;

    assert_unmapped_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && (dec_tgt == TGT_NONE)) |=> (rsp_rdata == '0));

    assert_word_read_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !req_dword) |=> (rsp_rdata[63:32] == '0));

    assert_idle_rdata_zero_R10: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> (rsp_rdata == '0));

endmodule

// File: tb/hart_timer_cmp_bench.sv
module hart_timer_cmp_bench;

    localparam int NH = 4;
    localparam logic [15:0] TB = 16'h7FF8;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en;
    logic        req_valid, req_write, req_dword;
    logic [15:0] req_addr;
    logic [63:0] req_wdata;
    logic [63:0] rsp_rdata;
    logic [NH-1:0] timer_irq;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    longint unsigned m_time;
    longint unsigned m_cmp [NH];
    logic [NH-1:0]   e_irq;
    logic [63:0]     e_rd;

    always #4 clk = ~clk;

    hart_timer_cmp u_hart_timer_cmp (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .req_valid(req_valid), .req_write(req_write), .req_dword(req_dword),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .timer_irq(timer_irq)
    );

    // -2: unmapped, -1: time, >=0: compare index
    function automatic int target_of(input logic [15:0] a);
        if (a % 4 != 0) return -2;
        if (a < 16'(NH * 8)) return int'(a / 8);
        if (a == TB || a == TB + 16'd4) return -1;
        return -2;
    endfunction

    function automatic longint unsigned merged(input longint unsigned old_v,
                                               input logic [63:0] wd,
                                               input logic dw, input logic hi);
        if (dw) return wd;
        if (hi) return {wd[31:0], old_v[31:0]};
        return {old_v[63:32], wd[31:0]};
    endfunction

    task automatic model_step();
        int t;
        logic hi;
        longint unsigned v;
        bit time_written;
        if (rst) begin
            m_time = 0;
            for (int i = 0; i < NH; i++) m_cmp[i] = '1;
            e_irq = '0;
            e_rd  = '0;
            return;
        end
        t  = target_of(req_addr);
        hi = req_addr[2];
        for (int i = 0; i < NH; i++) e_irq[i] = (m_cmp[i] <= m_time);
        e_rd = '0;
        if (req_valid && !req_write && t != -2) begin
            v = (t == -1) ? m_time : m_cmp[t];
            if (hi) e_rd = {32'h0, v[63:32]};
            else if (req_dword) e_rd = v;
            else e_rd = {32'h0, v[31:0]};
        end
        time_written = 0;
        if (req_valid && req_write && t != -2 && !(req_dword && hi)) begin
            if (t == -1) begin
                m_time = merged(m_time, req_wdata, req_dword, hi);
                time_written = 1;
            end else begin
                m_cmp[t] = merged(m_cmp[t], req_wdata, req_dword, hi);
            end
        end
        if (tick_en && !time_written) m_time = m_time + 1;
    endtask

    task automatic check_outputs();
        checks++;
        if (timer_irq !== e_irq) begin
            errors++;
            $display("FAIL %s (irq, R7): actual %b expected %b at %0t", cur_req, timer_irq, e_irq, $time);
        end
        checks++;
        if (rsp_rdata !== e_rd) begin
            errors++;
            $display("FAIL %s (rdata, R10): actual %h expected %h at %0t", cur_req, rsp_rdata, e_rd, $time);
        end
    endtask

    task automatic cyc(input logic v, input logic w, input logic dw,
                       input logic [15:0] a, input logic [63:0] d, input logic tk);
        req_valid = v; req_write = w; req_dword = dw;
        req_addr = a; req_wdata = d; tick_en = tk;
        @(posedge clk);
        #1;
        model_step();
        check_outputs();
    endtask

    task automatic idle(input int n, input logic tk);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 16'h0, 64'h0, tk);
    endtask

    task automatic rd(input logic [15:0] a, input logic dw);
        cyc(1, 0, dw, a, 64'h0, 0);
    endtask

    task automatic wr(input logic [15:0] a, input logic dw, input logic [63:0] d, input logic tk);
        cyc(1, 1, dw, a, d, tk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 0; req_write = 0; req_dword = 0;
        req_addr = '0; req_wdata = '0; tick_en = 0;
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 16'h0, 64'h0, 1);
        rst = 1'b0;

        // R1: reset values through the bus
        cur_req = "R1";
        rd(TB, 1);
        rd(16'h0000, 1);
        rd(16'h0018, 1);
        idle(1, 0);

        // R2: counting
        cur_req = "R2";
        idle(10, 1);
        idle(3, 0);
        rd(TB, 1);
        idle(1, 0);

        // R4/R5: half writes to hart 0 slot, then reach it
        cur_req = "R5";
        wr(16'h0000, 0, 64'hAAAA_BBBB_0000_0014, 0);
        rd(16'h0004, 0);
        rd(16'h0000, 0);
        wr(16'h0004, 0, 64'h0, 0);
        rd(16'h0000, 1);
        cur_req = "R7";
        idle(12, 1);

        // R4: hart 3 slot at stride 8
        cur_req = "R4";
        wr(16'h0018, 1, 64'h0000_0000_0000_0032, 0);
        rd(16'h001C, 0);
        rd(16'h0018, 0);
        idle(1, 0);

        // R6: doubleword at byte 4 of compare slot 1 ignored
        cur_req = "R6";
        wr(16'h000C, 1, 64'h0, 0);
        rd(16'h0008, 1);
        idle(2, 0);

        // R7: compare write into the past
        cur_req = "R7";
        wr(16'h0010, 1, 64'h5, 1);
        idle(2, 1);

        // R3: time write while ticking
        cur_req = "R3";
        wr(TB, 1, 64'd100, 1);
        rd(TB, 1);
        idle(2, 1);

        // R8: rewind time, irqs drop
        cur_req = "R8";
        wr(TB, 1, 64'd0, 1);
        idle(3, 0);
        wr(TB, 0, 64'd60, 0);
        idle(2, 0);

        // R5 on time: high-half word write while ticking
        cur_req = "R5";
        wr(TB + 16'd4, 0, 64'h1, 1);
        rd(TB + 16'd4, 1);
        rd(TB, 0);
        idle(1, 0);

        // R6 on time: bad doubleword at high word ignored, tick still counts
        cur_req = "R6";
        wr(TB + 16'd4, 1, 64'hDEAD_BEEF_DEAD_BEEF, 1);
        rd(TB, 1);
        idle(1, 0);

        // R9: unmapped accesses
        cur_req = "R9";
        rd(16'h0020, 1);
        rd(16'h0002, 0);
        rd(16'h1000, 1);
        wr(16'h0020, 1, 64'h0, 0);
        wr(16'h0006, 0, 64'h0, 0);
        rd(16'h0008, 1);
        rd(16'h0020, 0);
        idle(1, 0);

        // R7: compare crossing with a write landing the same cycle
        cur_req = "R7";
        wr(TB, 1, 64'd10, 0);
        wr(16'h0008, 1, 64'd12, 1);
        idle(4, 1);
        wr(16'h0008, 0, 64'd100, 1);
        idle(2, 1);

        // R10: word vs doubleword lanes
        cur_req = "R10";
        wr(16'h0010, 1, 64'h1234_5678_9ABC_DEF0, 0);
        rd(16'h0010, 1);
        rd(16'h0010, 0);
        rd(16'h0014, 1);
        idle(1, 0);

        // R1: reset again mid-run
        cur_req = "R1";
        rst = 1'b1;
        idle(2, 1);
        rst = 1'b0;
        rd(TB, 1);
        rd(16'h0010, 1);
        idle(2, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule